// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped, write-back, write-allocate data cache. It sits between a processor request port and a RAM port that moves one word per beat. Each line holds a valid flag, a dirty flag, a stored tag and `LINE_WORDS` data words. The processor presents one access at a time: an address, a read or write flag, write data and byte enables. It waits while `cpu_ready` is low and takes the result when `cpu_done` pulses.

A controller steps every access through named states. `ST_IDLE` accepts a request when `cpu_req` is high and goes to `ST_LOOKUP`. `ST_LOOKUP` compares the stored tag with the request tag:
- On a hit it reads the word or merges the write and goes to `ST_RESPOND`.
- On a miss it goes to `ST_WBACK` if the line is valid and dirty, to `ST_INVAL` if the line is valid and clean, and to `ST_FILL` if the line is invalid.

`ST_WBACK` writes out every word of the old line and then goes to `ST_INVAL`. `ST_INVAL` clears the valid flag and goes to `ST_FILL`. `ST_FILL` loads every word of the new line, sets the tag, sets valid, clears dirty, and returns to `ST_LOOKUP`, where the waiting request is replayed as a hit. `ST_RESPOND` pulses `cpu_done` and returns to `ST_IDLE`.

Top module: `dm_wb_cache`

## Requirements
- R1: With default parameters the 16-bit byte address splits into tag = bits [15:8], line index = bits [7:4], word-in-line = bits [3:2], and byte-in-word = bits [1:0], which is ignored. RAM addresses are byte addresses of 32-bit words, with bits [1:0] equal to zero.
- R2: After reset `cpu_ready` is 1, `cpu_done` is 0 and `mem_req` is 0. Every line is invalid, so the first access to any line reads the whole line from RAM.
- R3: An access to an invalid line issues exactly `LINE_WORDS` RAM reads at {request tag, index, word 0..last, 00} in ascending order and no RAM writes. It then returns the addressed word.
- R4: A read hit returns the addressed word with no RAM traffic. It leaves the line clean if it was clean.
- R5: A write hit replaces only the bytes whose `cpu_be` bit is 1 (bit k covers data bits [8k+7:8k]). It causes no RAM traffic and marks the line dirty.
- R6: A miss on a valid, clean line performs no RAM write before it fills the new line.
- R7: A miss on a valid, dirty line first writes all `LINE_WORDS` words to {stored tag, index, word 0..last, 00} in ascending order with the line's current contents. Only after that does it fill the new line.
- R8: A write miss allocates. The line is filled from RAM first, and the write data is then merged, so bytes that are not enabled keep their RAM value.
- R9: `cpu_ready` is 1 only in `ST_IDLE`. It is 0 from the cycle after acceptance until `cpu_done` has pulsed. `cpu_done` lasts one cycle and is followed by `cpu_ready`=1. A `cpu_req` raised while `cpu_ready` is 0 is ignored.
- R10: A hit completes with `cpu_done` high in the second cycle after the accepting clock edge.
- R11: A second write hit to a line that is already dirty keeps it dirty. The later eviction writes the line once and carries both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables for writes |
| cpu_ready | output | 1 | Idle and able to accept |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` on reads |
| mem_req | output | 1 | RAM beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Word-aligned RAM byte address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Beat accepted (and `mem_rdata` valid on fills) |
| mem_rdata | input | DATA_W | Fill data |

## Verification
A wrong valid flag or stored tag shows up at the ports on the next access to that index. A spurious hit returns stale data two cycles after acceptance, and a spurious miss produces a burst of RAM reads where none was expected. A lost dirty flag is not visible until the line is evicted: the expected write-back burst is missing and the RAM holds old data. A flag left set wrongly shows as an extra write-back burst. The directed scenarios therefore follow every write with an eviction, and they compare the RAM transaction log by order, address and data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_INVAL,
        ST_FILL,
        ST_RESPOND
    } wbc_state_e;

endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
    parameter int WADDR_W = 14,
    parameter int TAG_W   = 8,
    parameter int IDX_W   = 4,
    parameter int WSEL_W  = 2
) (
    input  logic [WADDR_W-1:0] waddr,
    output logic [TAG_W-1:0]   tag,
    output logic [IDX_W-1:0]   idx,
    output logic [WSEL_W-1:0]  wsel
);
    // word address = {tag, index, word-in-line}
    assign tag  = waddr[WADDR_W-1 -: TAG_W];
    assign idx  = waddr[WSEL_W +: IDX_W];
    assign wsel = waddr[WSEL_W-1:0];
endmodule

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             inval_en,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set_en,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel;
        assign sel = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (sel) begin
                if (fill_en) begin
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= 1'b0;
                end else if (inval_en) begin
                    valid_q[i] <= 1'b0;
                end else if (dirty_set_en) begin
                    dirty_q[i] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                tag_q[i] <= fill_tag;
            end
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int NUM_LINES  = 16,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int WSEL_W     = 2
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WSEL_W-1:0]   wr_wsel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [WSEL_W-1:0]   rd_wsel,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int BE_W  = DATA_W / 8;
    localparam int PTR_W = IDX_W + WSEL_W;
    localparam int DEPTH = NUM_LINES * LINE_WORDS;

    logic [DATA_W-1:0] words [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign wr_ptr = {idx, wr_wsel};
    assign rd_ptr = {idx, rd_wsel};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    words[wr_ptr][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    assign rd_data = words[rd_ptr];
endmodule

// File: rtl/wbc_ctrl_fsm.sv
module wbc_ctrl_fsm
    import wbc_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              req_we,
    input  logic              hit,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic              mem_ack,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              req_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WSEL_W-1:0] beat,
    output logic              tag_inval,
    output logic              tag_fill,
    output logic              dirty_set,
    output logic              data_hit_wr,
    output logic              data_fill_wr,
    output logic              rdata_load
);
    wbc_state_e state_q, state_d;
    logic [WSEL_W-1:0] beat_q;
    logic last_beat;

    assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));
    assign beat      = beat_q;

    // state register and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOOKUP || state_q == ST_INVAL) begin
                beat_q <= '0;
            end else if ((state_q == ST_WBACK || state_q == ST_FILL) && mem_ack) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)                           state_d = ST_RESPOND;
                else if (line_valid && line_dirty) state_d = ST_WBACK;
                else if (line_valid)               state_d = ST_INVAL;
                else                               state_d = ST_FILL;
            end
            ST_WBACK:   if (mem_ack && last_beat) state_d = ST_INVAL;
            ST_INVAL:   state_d = ST_FILL;
            ST_FILL:    if (mem_ack && last_beat) state_d = ST_LOOKUP;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready    = 1'b0;
        cpu_done     = 1'b0;
        req_load     = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        tag_inval    = 1'b0;
        tag_fill     = 1'b0;
        dirty_set    = 1'b0;
        data_hit_wr  = 1'b0;
        data_fill_wr = 1'b0;
        rdata_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                req_load  = cpu_req;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    data_hit_wr = req_we;
                    dirty_set   = req_we;
                    rdata_load  = !req_we;
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_INVAL: tag_inval = 1'b1;
            ST_FILL: begin
                mem_req      = 1'b1;
                data_fill_wr = mem_ack;
                tag_fill     = mem_ack && last_beat;
            end
            ST_RESPOND: cpu_done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W/8-1:0] cpu_be,
    output logic                cpu_ready,
    output logic                cpu_done,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int BE_W    = DATA_W / 8;
    localparam int BSEL_W  = $clog2(BE_W);
    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int WADDR_W = ADDR_W - BSEL_W;
    localparam int TAG_W   = WADDR_W - IDX_W - WSEL_W;

    // latched request
    logic [WADDR_W-1:0] req_waddr_q;
    logic               req_we_q;
    logic [DATA_W-1:0]  req_wdata_q;
    logic [BE_W-1:0]    req_be_q;
    logic [DATA_W-1:0]  rdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;

    logic              line_valid, line_dirty, hit;
    logic [TAG_W-1:0]  line_tag;
    logic              req_load, tag_inval, tag_fill, dirty_set;
    logic              data_hit_wr, data_fill_wr, rdata_load;
    logic [WSEL_W-1:0] beat;
    logic [WSEL_W-1:0] wr_wsel, rd_wsel;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [BE_W-1:0]   wr_be;

    wire unused_byte_sel = ^cpu_addr[BSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_waddr_q <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            req_be_q    <= '0;
        end else if (req_load) begin
            req_waddr_q <= cpu_addr[ADDR_W-1:BSEL_W];
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
            req_be_q    <= cpu_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rdata_load) begin
            rdata_q <= rd_data;
        end
    end

    assign cpu_rdata = rdata_q;

    wbc_addr_split #(
        .WADDR_W(WADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) split_i (
        .waddr(req_waddr_q),
        .tag  (req_tag),
        .idx  (req_idx),
        .wsel (req_wsel)
    );

    wbc_tag_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) tags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (req_idx),
        .inval_en    (tag_inval),
        .fill_en     (tag_fill),
        .fill_tag    (req_tag),
        .dirty_set_en(dirty_set),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .line_tag    (line_tag)
    );

    assign hit = line_valid && (line_tag == req_tag);

    // fill beats write whole words, hits merge under byte enables
    assign wr_wsel = data_fill_wr ? beat      : req_wsel;
    assign wr_data = data_fill_wr ? mem_rdata : req_wdata_q;
    assign wr_be   = data_fill_wr ? '1        : req_be_q;
    assign rd_wsel = mem_we       ? beat      : req_wsel;

    wbc_data_store #(
        .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) data_i (
        .clk    (clk),
        .wr_en  (data_hit_wr || data_fill_wr),
        .idx    (req_idx),
        .wr_wsel(wr_wsel),
        .wr_data(wr_data),
        .wr_be  (wr_be),
        .rd_wsel(rd_wsel),
        .rd_data(rd_data)
    );

    wbc_ctrl_fsm #(
        .LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .req_we      (req_we_q),
        .hit         (hit),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .mem_ack     (mem_ack),
        .cpu_ready   (cpu_ready),
        .cpu_done    (cpu_done),
        .req_load    (req_load),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .beat        (beat),
        .tag_inval   (tag_inval),
        .tag_fill    (tag_fill),
        .dirty_set   (dirty_set),
        .data_hit_wr (data_hit_wr),
        .data_fill_wr(data_fill_wr),
        .rdata_load  (rdata_load)
    );

    // write-back uses the stored tag, fill uses the request tag
    assign mem_addr  = {(mem_we ? line_tag : req_tag), req_idx, beat, {BSEL_W{1'b0}}};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/dm_wb_cache_checker.sv
module dm_wb_cache_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_req,
    input logic                cpu_ready,
    input logic                cpu_done,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ack
);
    a_r9_ready_not_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && cpu_done));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> cpu_ready);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready);

    a_r9_no_ram_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    a_r7_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind dm_wb_cache dm_wb_cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .cpu_done (cpu_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/dm_wb_cache_tb_top.sv
`timescale 1ns/1ps
module dm_wb_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready, cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dm_wb_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;

    // RAM model with a transaction log
    logic [31:0] ram [int unsigned];
    logic [15:0] log_addr [32];
    logic        log_we   [32];
    logic [31:0] log_data [32];
    int          log_n = 0;

    function automatic logic [31:0] init_word(logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    function automatic logic [31:0] ram_rd(logic [15:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return init_word(a);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (log_n < 32) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_data[log_n] = mem_wdata;
            end
            log_n = log_n + 1;
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= ram_rd(mem_addr);
        end
    end

    // watchdog
    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d cycles", cyc_total, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one processor access; returns data and cycles from acceptance to done
    task automatic access(logic we, logic [15:0] a, logic [31:0] wd, logic [3:0] be,
                          output logic [31:0] rd, output int cyc);
        bit ready_seen = 0;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        log_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        @(negedge clk);
        cpu_req = 1'b0;
        cyc = 1;
        while (!cpu_done) begin
            if (cpu_ready) ready_seen = 1;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        check("R9", 32'(ready_seen), 0, "cpu_ready high while busy");
        @(negedge clk);
        check("R9", 32'(cpu_ready), 1, "cpu_ready after done");
    endtask

    task automatic expect_fill(string req, logic [15:0] base, int first);
        for (int k = 0; k < 4; k++) begin
            check(req, 32'(log_we[first+k]), 0, "fill beat is read");
            check(req, 32'(log_addr[first+k]), 32'(base + 16'(4*k)), "fill beat address");
        end
    endtask

    task automatic expect_wback(string req, logic [15:0] base);
        for (int k = 0; k < 4; k++) begin
            check(req, 32'(log_we[k]), 1, "write-back beat is write");
            check(req, 32'(log_addr[k]), 32'(base + 16'(4*k)), "write-back address");
        end
    endtask

    logic [31:0] d;
    int          c;

    task automatic t_reset;
        check("R2", 32'(cpu_ready), 1, "ready after reset");
        check("R2", 32'(cpu_done), 0, "done after reset");
        check("R2", 32'(mem_req), 0, "mem_req after reset");
    endtask

    task automatic t_cold_read;
        access(0, 16'h1234, 0, 0, d, c);
        check("R3", 32'(log_n), 4, "cold read beat count");
        expect_fill("R3", 16'h1230, 0);
        check("R3", d, init_word(16'h1234), "cold read data");
        access(0, 16'h12F6, 0, 0, d, c);          // R1: index F, byte bits ignored
        check("R1", 32'(log_n), 4, "other index fills");
        expect_fill("R1", 16'h12F0, 0);
        check("R1", d, init_word(16'h12F4), "byte bits ignored");
    endtask

    task automatic t_read_hit;
        access(0, 16'h1238, 0, 0, d, c);
        check("R4", 32'(log_n), 0, "read hit RAM traffic");
        check("R4", d, init_word(16'h1238), "read hit data");
        check("R10", 32'(c), 2, "hit latency");
    endtask

    task automatic t_write_hits;
        access(1, 16'h1238, 32'hDEADBEEF, 4'b0101, d, c);
        check("R5", 32'(log_n), 0, "write hit RAM traffic");
        check("R10", 32'(c), 2, "write hit latency");
        access(1, 16'h123C, 32'hCAFEF00D, 4'b1111, d, c);   // R11 second write
        access(0, 16'h1238, 0, 0, d, c);
        check("R5", d, merge(init_word(16'h1238), 32'hDEADBEEF, 4'b0101), "merged bytes");
    endtask

    task automatic t_dirty_evict;
        access(0, 16'h5634, 0, 0, d, c);
        check("R7", 32'(log_n), 8, "dirty miss beat count");
        expect_wback("R7", 16'h1230);
        check("R7", log_data[0], init_word(16'h1230), "write-back word 0");
        check("R11", log_data[2], merge(init_word(16'h1238), 32'hDEADBEEF, 4'b0101), "first write kept");
        check("R11", log_data[3], 32'hCAFEF00D, "second write kept");
        expect_fill("R7", 16'h5630, 4);
        check("R7", d, init_word(16'h5634), "data after eviction");
    endtask

    task automatic t_clean_evict;
        access(0, 16'h7730, 0, 0, d, c);
        check("R6", 32'(log_n), 4, "clean miss has no write-back");
        expect_fill("R6", 16'h7730, 0);
        check("R4", d, init_word(16'h7730), "read after clean miss");
    endtask

    task automatic t_write_allocate;
        access(1, 16'h9A48, 32'h11223344, 4'b0011, d, c);
        check("R8", 32'(log_n), 4, "write miss fills first");
        expect_fill("R8", 16'h9A40, 0);
        access(0, 16'hBC48, 0, 0, d, c);
        check("R8", 32'(log_n), 8, "allocated line evicted dirty");
        check("R8", 32'(log_addr[2]), 32'h9A48, "merged word address");
        check("R8", log_data[2], merge(init_word(16'h9A48), 32'h11223344, 4'b0011), "merged with RAM bytes");
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        log_n = 0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h3300;
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'h3304; cpu_wdata = 32'hFFFFFFFF; cpu_be = 4'hF;
        while (!cpu_done) @(negedge clk);
        cpu_req = 1'b0;
        check("R9", cpu_rdata, init_word(16'h3300), "busy access data");
        access(0, 16'h3304, 0, 0, d, c);
        check("R9", d, init_word(16'h3304), "request while busy ignored");
        check("R9", 32'(log_n), 0, "ignored request made no traffic");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_read();
        t_read_hit();
        t_write_hits();
        t_dirty_evict();
        t_clean_evict();
        t_write_allocate();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule